// File: doc/BRIEF.md
# Triggered Command Set Sequencer

This block holds a small set of bus commands that software programs through a word-addressed register port. Each command slot stores a message-ID word, a target address and a data word, and has a read-only status word. A bitmap selects which slots take part in the next run. Software starts a run with a two-step handshake: it first sets the mode-enable bit on its own, then sets the trigger bit. The sequencer then sends the enabled commands on a request/acknowledge port, one at a time, from the lowest slot upward.

A command may ask for a completion response, which returns on a separate completion input tagged with the slot index. Write-only commands count as complete as soon as they are accepted. When every enabled slot reports complete while the trigger is still set, the block sets its done status bit and, if the interrupt is unmasked, raises its interrupt output. Software clears the trigger before the mode-enable to stop, and writes a one to the clear register to acknowledge the interrupt. The downstream fabric is stood in for by the acknowledge and completion inputs.

Top module: `tcs_sequencer`

## Requirements
- R1: After reset, cmd_req and irq are low and the control, command-enable, interrupt-enable and interrupt-status registers read zero.
- R2: The control register (word 3) holds mode-enable at bit 16 and trigger at bit 24. A write sets trigger only if mode-enable was already set before that write and stays set by it; a write that clears mode-enable also clears trigger. A written value reads back on a read issued in the next cycle.
- R3: On a rising trigger, enabled slots are requested in ascending slot order, one at a time. A request stays high with stable fields until cmd_ack. cmd_addr and cmd_data are the slot's address (field 1) and data (field 2) words, cmd_resp is bit 8 and cmd_write is bit 16 of its message-ID word (field 0). Slot s occupies words 16+4s to 19+4s.
- R4: A slot's status word (field 3) shows issued at bit 8 and completed at bit 16. A write-only command completes when it is accepted. A response-required command completes only on cmp_valid carrying its slot index.
- R5: The done bit (bit 0 of the status register, word 1) is set only once every enabled slot has completed while trigger is still set. It stays clear while any response is outstanding. An empty enable bitmap gives done at once.
- R6: If trigger is cleared during a run, the request in progress finishes its handshake, no further slot is requested, and done is not set.
- R7: Writing zero to the command-enable register (word 4, one bit per slot) clears every slot's status. While a run is active, writes to the command-enable register and to slot words are ignored.
- R8: irq is high exactly when the done bit and bit 0 of the interrupt-enable register (word 0) are both set. Writing a one to bit 0 of the clear register (word 2) clears the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address (write and read) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for reg_addr of the previous cycle |
| cmd_req | output | 1 | Command request valid |
| cmd_ack | input | 1 | Command accepted by the fabric |
| cmd_addr | output | DW | Target address of the requested command |
| cmd_data | output | DW | Data word of the requested command |
| cmd_resp | output | 1 | Command expects a completion response |
| cmd_write | output | 1 | Command is a write |
| cmp_valid | input | 1 | Completion response strobe |
| cmp_slot | input | log2(NSLOT) | Slot index of the completion response |
| irq | output | 1 | Done interrupt |

## Verification
A wrong pending vector or a broken priority pick shows up on the very next request as an address that breaks ascending slot order or a slot that is sent twice. Lost completion tracking shows up within two cycles of the last acknowledge or completion as irq rising early, or never. A trigger gate that lets a lone trigger write through, or that ignores a cleared trigger, shows up as a request that should not appear within a few cycles. Slot status corruption is visible on the next read of the status word, and the bench reads every slot's status after each run of the sweep.

// File: rtl/tcs_seq_pkg.sv
package tcs_seq_pkg;
  // control word bit positions
  localparam int CTRL_MODE_BIT = 16;
  localparam int CTRL_TRIG_BIT = 24;
  // message-ID word flags
  localparam int MSG_RESP_BIT  = 8;
  localparam int MSG_WRITE_BIT = 16;
  // slot status word flags
  localparam int ST_ISSUED_BIT = 8;
  localparam int ST_DONE_BIT   = 16;
  // register word map
  localparam int REG_IRQ_EN   = 0;
  localparam int REG_IRQ_STAT = 1;
  localparam int REG_IRQ_CLR  = 2;
  localparam int REG_CTRL     = 3;
  localparam int REG_CMD_EN   = 4;
  localparam int SLOT_BASE    = 16;
  // slot field offsets
  localparam logic [1:0] FLD_MSGID = 2'd0;
  localparam logic [1:0] FLD_ADDR  = 2'd1;
  localparam logic [1:0] FLD_DATA  = 2'd2;
  localparam logic [1:0] FLD_STAT  = 2'd3;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/tcs_seq_regs.sv
module tcs_seq_regs
  import tcs_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int IDXW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [NSLOT-1:0] issued,
  input  logic [NSLOT-1:0] completed,
  input  logic [IDXW-1:0]  pick_idx,
  output logic             mode_en,
  output logic             trigger,
  output logic [NSLOT-1:0] cmd_en,
  output logic [NSLOT-1:0] resp_vec,
  output logic [DW-1:0]    sel_msgid,
  output logic [DW-1:0]    sel_addr,
  output logic [DW-1:0]    sel_data,
  output logic             clr_status,
  output logic             irq
);
  localparam int SLOT_END = SLOT_BASE + 4 * NSLOT;

  logic [DW-1:0] msgid_mem [NSLOT];
  logic [DW-1:0] addr_mem  [NSLOT];
  logic [DW-1:0] data_mem  [NSLOT];

  logic          irq_en_q, irq_stat_q;
  logic          irq_en_n, irq_stat_n;
  logic          mode_n, trig_n;
  logic [AW-1:0] slot_off;
  logic [IDXW-1:0] slot_i;
  logic [1:0]    fld;
  logic          is_slot, slot_wr, clr_hit, en_wr;
  logic [DW-1:0] rd_n;

  assign slot_off = reg_addr - AW'(SLOT_BASE);
  assign slot_i   = slot_off[IDXW+1:2];
  assign fld      = slot_off[1:0];
  assign is_slot  = (int'(reg_addr) >= SLOT_BASE) && (int'(reg_addr) < SLOT_END);
  assign slot_wr  = reg_we && is_slot && !busy;
  assign en_wr    = reg_we && (reg_addr == AW'(REG_CMD_EN)) && !busy;
  assign clr_hit  = reg_we && (reg_addr == AW'(REG_IRQ_CLR)) && reg_wdata[0];
  assign clr_status = en_wr && (reg_wdata[NSLOT-1:0] == '0);

  // slot storage, one write port per array, no reset
  always_ff @(posedge clk) begin
    if (slot_wr && fld == FLD_MSGID) msgid_mem[slot_i] <= reg_wdata;
  end
  always_ff @(posedge clk) begin
    if (slot_wr && fld == FLD_ADDR) addr_mem[slot_i] <= reg_wdata;
  end
  always_ff @(posedge clk) begin
    if (slot_wr && fld == FLD_DATA) data_mem[slot_i] <= reg_wdata;
  end

  assign sel_msgid = msgid_mem[pick_idx];
  assign sel_addr  = addr_mem[pick_idx];
  assign sel_data  = data_mem[pick_idx];

  for (genvar i = 0; i < NSLOT; i++) begin : g_resp
    assign resp_vec[i] = msgid_mem[i][MSG_RESP_BIT];
  end

  // control word: trigger accepted only on top of an already set mode-enable
  always_comb begin
    mode_n = mode_en;
    trig_n = trigger;
    if (reg_we && reg_addr == AW'(REG_CTRL)) begin
      mode_n = reg_wdata[CTRL_MODE_BIT];
      trig_n = reg_wdata[CTRL_TRIG_BIT] && reg_wdata[CTRL_MODE_BIT] && mode_en;
    end
  end

  always_comb begin
    irq_en_n = irq_en_q;
    if (reg_we && reg_addr == AW'(REG_IRQ_EN)) irq_en_n = reg_wdata[0];
    irq_stat_n = (irq_stat_q && !clr_hit) || done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_en    <= 1'b0;
      trigger    <= 1'b0;
      cmd_en     <= '0;
      irq_en_q   <= 1'b0;
      irq_stat_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      mode_en    <= mode_n;
      trigger    <= trig_n;
      irq_en_q   <= irq_en_n;
      irq_stat_q <= irq_stat_n;
      irq        <= irq_stat_n && irq_en_n;
      if (en_wr) cmd_en <= reg_wdata[NSLOT-1:0];
    end
  end

  // registered read-back
  always_comb begin
    rd_n = '0;
    if (is_slot) begin
      case (fld)
        FLD_MSGID: rd_n = msgid_mem[slot_i];
        FLD_ADDR:  rd_n = addr_mem[slot_i];
        FLD_DATA:  rd_n = data_mem[slot_i];
        default: begin
          rd_n[ST_ISSUED_BIT] = issued[slot_i];
          rd_n[ST_DONE_BIT]   = completed[slot_i];
        end
      endcase
    end else if (reg_addr == AW'(REG_IRQ_EN)) begin
      rd_n[0] = irq_en_q;
    end else if (reg_addr == AW'(REG_IRQ_STAT)) begin
      rd_n[0] = irq_stat_q;
    end else if (reg_addr == AW'(REG_CTRL)) begin
      rd_n[CTRL_MODE_BIT] = mode_en;
      rd_n[CTRL_TRIG_BIT] = trigger;
    end else if (reg_addr == AW'(REG_CMD_EN)) begin
      rd_n[NSLOT-1:0] = cmd_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end

  AST_TRIG_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    trigger |-> mode_en); // R2
  AST_DONE_UNDER_TRIG: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_stat_q) |-> $past(trigger)); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !done) |=> !irq_stat_q); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_stat_q && irq_en_q)); // R8
endmodule

// File: rtl/tcs_seq_pick.sv
module tcs_seq_pick #(
  parameter int NSLOT = 16,
  parameter int IDXW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0] pend,
  output logic [IDXW-1:0]  idx,
  output logic             any
);
  logic [NSLOT-1:0] seen;
  logic [NSLOT-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 1; i < NSLOT; i++) begin : g_seen
    assign seen[i] = seen[i-1] | pend[i-1];
  end
  for (genvar i = 0; i < NSLOT; i++) begin : g_grant
    assign grant[i] = pend[i] & ~seen[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (grant[i]) idx = idx | IDXW'(i);
    end
  end

  assign any = |pend;

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R3
  end
endmodule

// File: rtl/tcs_seq_issue.sv
module tcs_seq_issue
  import tcs_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int IDXW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic             trigger,
  input  logic [NSLOT-1:0] cmd_en,
  input  logic [NSLOT-1:0] resp_vec,
  input  logic             clr_status,
  input  logic [IDXW-1:0]  pick_idx,
  input  logic             pick_any,
  input  logic [DW-1:0]    sel_msgid,
  input  logic [DW-1:0]    sel_addr,
  input  logic [DW-1:0]    sel_data,
  input  logic             cmd_ack,
  input  logic             cmp_valid,
  input  logic [IDXW-1:0]  cmp_slot,
  output logic             cmd_req,
  output logic [DW-1:0]    cmd_addr,
  output logic [DW-1:0]    cmd_data,
  output logic             cmd_resp,
  output logic             cmd_write,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] issued,
  output logic [NSLOT-1:0] completed,
  output logic             busy,
  output logic             done
);
  seq_state_e      state;
  logic            trig_q;
  logic [IDXW-1:0] cur;
  logic            cmp_hit;

  assign busy    = (state == SEQ_RUN);
  assign pend    = cmd_en & ~issued;
  assign cmp_hit = cmp_valid && busy && (int'(cmp_slot) < NSLOT)
                   && issued[cmp_slot] && resp_vec[cmp_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      trig_q    <= 1'b0;
      cur       <= '0;
      cmd_req   <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_resp  <= 1'b0;
      cmd_write <= 1'b0;
      issued    <= '0;
      completed <= '0;
      done      <= 1'b0;
    end else begin
      trig_q <= trigger;
      done   <= 1'b0;
      if (clr_status) begin
        issued    <= '0;
        completed <= '0;
      end
      case (state)
        SEQ_IDLE: begin
          if (trigger && !trig_q) begin
            issued    <= '0;
            completed <= '0;
            state     <= SEQ_RUN;
          end
        end
        default: begin
          if (cmd_req) begin
            if (cmd_ack) begin
              cmd_req     <= 1'b0;
              issued[cur] <= 1'b1;
              if (!cmd_resp) completed[cur] <= 1'b1;
            end
          end else if (!trigger) begin
            state <= SEQ_IDLE;
          end else if (pick_any) begin
            cmd_req   <= 1'b1;
            cur       <= pick_idx;
            cmd_addr  <= sel_addr;
            cmd_data  <= sel_data;
            cmd_resp  <= sel_msgid[MSG_RESP_BIT];
            cmd_write <= sel_msgid[MSG_WRITE_BIT];
          end else if ((completed & cmd_en) == cmd_en) begin
            done  <= 1'b1;
            state <= SEQ_IDLE;
          end
        end
      endcase
      if (cmp_hit) completed[cmp_slot] <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_addr) && $stable(cmd_data))); // R3
  AST_REQ_START_TRIG: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_req) |-> ($past(trigger) && $past(mode_en))); // R2
  AST_CMP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (completed & ~issued) == '0); // R4
  AST_DONE_ALL_EN: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_req && !busy); // R5
endmodule

// File: rtl/tcs_sequencer.sv
module tcs_sequencer
  import tcs_seq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          cmd_req,
  input  logic          cmd_ack,
  output logic [DW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_resp,
  output logic          cmd_write,
  input  logic          cmp_valid,
  input  logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] cmp_slot,
  output logic          irq
);
  localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic             mode_en, trigger, busy, done, clr_status, pick_any;
  logic [NSLOT-1:0] cmd_en, resp_vec, pend, issued, completed;
  logic [IDXW-1:0]  pick_idx;
  logic [DW-1:0]    sel_msgid, sel_addr, sel_data;

  tcs_seq_regs #(.NSLOT(NSLOT), .DW(DW), .AW(AW), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .issued(issued), .completed(completed),
    .pick_idx(pick_idx), .mode_en(mode_en), .trigger(trigger), .cmd_en(cmd_en),
    .resp_vec(resp_vec), .sel_msgid(sel_msgid), .sel_addr(sel_addr), .sel_data(sel_data),
    .clr_status(clr_status), .irq(irq)
  );

  tcs_seq_pick #(.NSLOT(NSLOT), .IDXW(IDXW)) u_pick (
    .pend(pend), .idx(pick_idx), .any(pick_any)
  );

  tcs_seq_issue #(.NSLOT(NSLOT), .DW(DW), .IDXW(IDXW)) u_issue (
    .clk(clk), .rst(rst), .mode_en(mode_en), .trigger(trigger), .cmd_en(cmd_en),
    .resp_vec(resp_vec), .clr_status(clr_status), .pick_idx(pick_idx), .pick_any(pick_any),
    .sel_msgid(sel_msgid), .sel_addr(sel_addr), .sel_data(sel_data),
    .cmd_ack(cmd_ack), .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
    .cmd_req(cmd_req), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_resp(cmd_resp),
    .cmd_write(cmd_write), .pend(pend), .issued(issued), .completed(completed),
    .busy(busy), .done(done)
  );
endmodule

// File: tb/tcs_sequencer_bench.sv
module tcs_sequencer_bench;
  localparam int NSLOT = 4;
  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int IDXW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          cmd_req, cmd_resp, cmd_write, irq;
  logic          cmd_ack = 1'b0;
  logic [DW-1:0] cmd_addr, cmd_data;
  logic          cmp_valid = 1'b0;
  logic [IDXW-1:0] cmp_slot = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tcs_sequencer #(.NSLOT(NSLOT), .DW(DW), .AW(AW)) u_tcs_sequencer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_resp(cmd_resp), .cmd_write(cmd_write),
    .cmp_valid(cmp_valid), .cmp_slot(cmp_slot), .irq(irq)
  );

  localparam logic [31:0] C_MODE = 32'h0001_0000;
  localparam logic [31:0] C_BOTH = 32'h0101_0000;
  localparam logic [31:0] ST_FULL = 32'h0001_0100;
  localparam logic [31:0] ST_ISS  = 32'h0000_0100;

  function automatic logic [31:0] s_addr(input int s); return 32'h0000_3000 + 32'(s * 17); endfunction
  function automatic logic [31:0] s_data(input int s); return 32'hA500_0000 + 32'(s * 257); endfunction
  function automatic logic [7:0] s_reg(input int s, input int f); return 8'(16 + 4 * s + f); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_req(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (cmd_req) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic ack_one();
    cmd_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_ack = 1'b0;
  endtask

  task automatic complete(input int s);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_slot = IDXW'(s);
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic run_case(input logic [3:0] mask, input logic [3:0] rp);
    logic [31:0] v;
    bit ok;
    for (int s = 0; s < NSLOT; s++)
      wr(s_reg(s, 0), 32'h0001_0008 | (32'(rp[s]) << 8));
    wr(8'd4, 32'(mask));
    wr(8'd3, C_MODE);
    rd(8'd3, v);
    chk("R2 mode-enable readback", v, C_MODE);
    wr(8'd3, C_BOTH);
    for (int s = 0; s < NSLOT; s++) begin
      if (mask[s]) begin
        wait_req(ok);
        chk("R3 request appears", 32'(ok), 32'd1);
        if (ok) begin
          chk("R3 ascending slot addr", cmd_addr, s_addr(s));
          chk("R3 data word", cmd_data, s_data(s));
          chk("R3 resp flag", 32'(cmd_resp), 32'(rp[s]));
          chk("R3 write flag", 32'(cmd_write), 32'd1);
          ack_one();
          chk("R3 request drops after ack", 32'(cmd_req), 32'd0);
          if ((rp & mask) != 0) chk("R5 no done with response owed", 32'(irq), 32'd0);
        end
      end
    end
    repeat (4) @(negedge clk);
    chk("R3 no extra request", 32'(cmd_req), 32'd0);
    if ((rp & mask) != 0) begin
      chk("R5 done held for responses", 32'(irq), 32'd0);
      for (int s = NSLOT - 1; s >= 0; s--) begin
        if (mask[s] && rp[s]) begin
          rd(s_reg(s, 3), v);
          chk("R4 issued without completion", v, ST_ISS);
          complete(s);
        end
      end
      repeat (4) @(negedge clk);
    end
    chk("R5 done interrupt raised", 32'(irq), 32'd1);
    rd(8'd1, v);
    chk("R5 done status bit", v, 32'd1);
    for (int s = 0; s < NSLOT; s++) begin
      rd(s_reg(s, 3), v);
      chk("R4 slot status after run", v, mask[s] ? ST_FULL : 32'd0);
    end
    wr(8'd2, 32'd1);
    @(negedge clk);
    chk("R8 irq cleared by W1C", 32'(irq), 32'd0);
    rd(8'd1, v);
    chk("R8 status cleared by W1C", v, 32'd0);
    wr(8'd3, C_MODE);
    wr(8'd3, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cmd_req after reset", 32'(cmd_req), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd(8'd3, v); chk("R1 control reset", v, 32'd0);
    rd(8'd4, v); chk("R1 enable reset", v, 32'd0);
    rd(8'd1, v); chk("R1 status reset", v, 32'd0);
    rd(8'd0, v); chk("R1 irq enable reset", v, 32'd0);

    for (int s = 0; s < NSLOT; s++) begin
      wr(s_reg(s, 1), s_addr(s));
      wr(s_reg(s, 2), s_data(s));
    end
    rd(s_reg(2, 1), v); chk("R2 slot addr readback", v, s_addr(2));
    wr(8'd0, 32'd1);

    // R2: trigger without prior mode-enable is rejected
    wr(8'd4, 32'd3);
    wr(8'd3, 32'h0100_0000);
    rd(8'd3, v); chk("R2 lone trigger rejected", v, 32'd0);
    wr(8'd3, C_BOTH);
    rd(8'd3, v); chk("R2 joint write keeps only mode", v, C_MODE);
    repeat (8) @(negedge clk);
    chk("R2 no request without two-step start", 32'(cmd_req), 32'd0);
    wr(8'd3, 32'd0);

    // sweep of masks and response patterns
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 4; r++) begin
        logic [3:0] rp;
        case (r)
          0: rp = 4'h0;
          1: rp = 4'hF;
          2: rp = 4'h5;
          default: rp = 4'hA;
        endcase
        run_case(4'(m), rp);
      end
    end

    // R6 / R7: abort mid-run, writes ignored while busy
    wr(s_reg(0, 0), 32'h0001_0108);
    wr(s_reg(1, 0), 32'h0001_0008);
    wr(8'd4, 32'd3);
    wr(8'd3, C_MODE);
    wr(8'd3, C_BOTH);
    @(negedge clk);
    wait_req(ok);
    chk("R6 first request of aborted run", 32'(ok), 32'd1);
    wr(8'd3, C_MODE);
    wr(8'd4, 32'hC);
    wr(s_reg(1, 1), 32'hDEAD_0000);
    chk("R3 request held without ack", 32'(cmd_req), 32'd1);
    ack_one();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cmd_req) begin chk("R6 no request after trigger cleared", 32'd1, 32'd0); break; end
    end
    chk("R6 no done after abort", 32'(irq), 32'd0);
    rd(8'd1, v); chk("R6 status stays clear", v, 32'd0);
    rd(s_reg(0, 3), v); chk("R6 slot0 issued only", v, ST_ISS);
    rd(s_reg(1, 3), v); chk("R6 slot1 never issued", v, 32'd0);
    rd(8'd4, v); chk("R7 enable write ignored while busy", v, 32'd3);
    rd(s_reg(1, 1), v); chk("R7 slot write ignored while busy", v, s_addr(1));

    // R7 discard
    wr(8'd4, 32'd0);
    rd(8'd4, v); chk("R7 enable cleared", v, 32'd0);
    rd(s_reg(0, 3), v); chk("R7 status discarded", v, 32'd0);

    // R8 masked interrupt, R5 empty set
    wr(8'd0, 32'd0);
    wr(8'd3, C_BOTH);
    repeat (4) @(negedge clk);
    rd(8'd1, v); chk("R5 empty set done at once", v, 32'd1);
    chk("R8 irq masked", 32'(irq), 32'd0);
    wr(8'd0, 32'd1);
    @(negedge clk);
    chk("R8 irq unmasked", 32'(irq), 32'd1);
    wr(8'd2, 32'd1);
    @(negedge clk);
    chk("R8 irq cleared", 32'(irq), 32'd0);
    wr(8'd3, C_MODE);
    wr(8'd3, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule